// File: doc/BRIEF.md
# Configuration Bitstream Header Parser

This block inspects a configuration file as it streams past, one byte per accepted handshake. A one-cycle start strobe clears all earlier results and latches the total file length, given in bytes. The parser then skips leading bytes until it meets the first 0xFF marker byte and reports that byte's position as the offset where the configuration data starts.

The four bytes after the marker form a header. The first of them carries a sync nibble. Together the four bytes hold a 24-bit payload length in bits, spread across nibble boundaries. The parser checks the sync nibble, assembles the bit count, and checks that the declared payload fits in the file. It finishes with a one-cycle done pulse and at most one error flag: start not found, header corrupted, or file too small. Once a parse is finished it takes no more bytes until the next start strobe.

Top module: `cfg_hdr_parser`

## Requirements
- R1: After reset, byteReady, doneOut and all three error flags are low, and dataOffset and bitCount are zero.
- R2: A start strobe clears the error flags, dataOffset and bitCount, and latches fileLen. In the cycle after the strobe, byteReady is high whenever fileLen is non-zero.
- R3: Bytes before the first 0xFF are consumed and ignored. dataOffset equals the zero-based index of that first 0xFF.
- R4: If fileLen bytes have been taken without an 0xFF among them, errNoStart is set and the parse ends. With fileLen zero, no byte is taken at all.
- R5: The byte after the marker must have 0x2 in bits 7:4. Otherwise errBadHdr is set, and that byte is the last one taken.
- R6: For header bytes h0..h3 after the marker, bitCount = {h0[3:0], h1, h2, h3[7:4]}.
- R7: errTooSmall is set when dataOffset + floor(bitCount/8) > fileLen. Equality passes.
- R8: If the byte count reaches fileLen before all four header bytes have been taken, errTooSmall is set.
- R9: Each parse produces exactly one doneOut pulse, one cycle wide, and at most one error flag. A flag only rises together with doneOut.
- R10: byteReady is low from the end of a parse until the next start. The total number of bytes taken is exactly the number the parse needs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Start-of-file strobe, one cycle |
| fileLen | input | 32 | Total file length in bytes, sampled with startIn |
| byteValid | input | 1 | Source has a byte on byteData |
| byteData | input | 8 | File byte |
| byteReady | output | 1 | Parser accepts a byte this cycle |
| doneOut | output | 1 | One-cycle pulse at end of parse |
| dataOffset | output | 32 | Index of the marker byte |
| bitCount | output | 24 | Declared payload length in bits |
| errNoStart | output | 1 | No marker within the file |
| errBadHdr | output | 1 | Sync nibble mismatch |
| errTooSmall | output | 1 | Payload does not fit, or header truncated |

## Verification
dataOffset is due on the edge that accepts the marker. bitCount is due on the edge that accepts the last header byte. For a full header, doneOut and errTooSmall follow two edges after that last byte, because one compare cycle sits in between. For the start-not-found, truncation and bad-sync cases, doneOut and the flag appear one edge after the deciding condition. The bench drives inputs and samples outputs at falling edges. It counts accepted bytes by reading byteReady half a cycle before each rising edge. It checks the results only after the done pulse has been seen, and it keeps watching for four cycles afterwards to catch a second pulse or a stray accepted byte.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int HDR_BYTES = 4;
  localparam int CNT_W     = 24;

  typedef enum logic [2:0] {
    PS_IDLE, PS_SCAN, PS_HDR0, PS_HDR1, PS_HDR2, PS_HDR3, PS_CHECK, PS_DONE
  } parseState_t;

  typedef struct packed {
    logic                 clr;
    logic                 take;
    logic                 capMark;
    logic [HDR_BYTES-1:0] capHdr;
    logic                 setNoStart;
    logic                 setBadHdr;
    logic                 setShort;
    logic                 checkLen;
  } ctlStrobe_t;

  typedef struct packed {
    logic atEnd;
    logic isMarker;
    logic syncOk;
  } dpStatus_t;
endpackage

// File: rtl/cfg_hdr_dpath.sv
module cfg_hdr_dpath
  import cfg_hdr_pkg::*;
#(
  parameter int        LEN_W    = 32,
  parameter logic [7:0] MARKER  = 8'hFF,
  parameter logic [3:0] SYNC_NIB = 4'h2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       stb,
  input  logic [LEN_W-1:0] fileLenIn,
  input  logic [7:0]       byteData,
  output dpStatus_t        status,
  output logic [LEN_W-1:0] dataOffset,
  output logic [CNT_W-1:0] bitCount,
  output logic             errNoStart,
  output logic             errBadHdr,
  output logic             errTooSmall
);
  localparam int SUM_W = LEN_W + 1;

  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] idxQ;
  logic [LEN_W-1:0] markQ;
  logic [7:0]       hdrQ [HDR_BYTES];
  logic [SUM_W-1:0] endSum;
  logic             tooSmall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ  <= '0;
      idxQ  <= '0;
      markQ <= '0;
    end else if (stb.clr) begin
      lenQ  <= fileLenIn;
      idxQ  <= '0;
      markQ <= '0;
    end else begin
      if (stb.take)    idxQ  <= idxQ + 1'b1;
      if (stb.capMark) markQ <= idxQ;
    end
  end

  for (genvar k = 0; k < HDR_BYTES; k++) begin : g_hdr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              hdrQ[k] <= '0;
      else if (stb.clr)       hdrQ[k] <= '0;
      else if (stb.capHdr[k]) hdrQ[k] <= byteData;
    end
  end

  // payload length straddles nibble boundaries of the four header bytes
  assign bitCount = {hdrQ[0][3:0], hdrQ[1], hdrQ[2], hdrQ[3][7:4]};

  assign endSum   = SUM_W'(markQ) + SUM_W'(bitCount >> 3);
  assign tooSmall = endSum > SUM_W'(lenQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errNoStart  <= 1'b0;
      errBadHdr   <= 1'b0;
      errTooSmall <= 1'b0;
    end else if (stb.clr) begin
      errNoStart  <= 1'b0;
      errBadHdr   <= 1'b0;
      errTooSmall <= 1'b0;
    end else begin
      if (stb.setNoStart) errNoStart <= 1'b1;
      if (stb.setBadHdr)  errBadHdr  <= 1'b1;
      if (stb.setShort || (stb.checkLen && tooSmall)) errTooSmall <= 1'b1;
    end
  end

  assign status.atEnd    = idxQ >= lenQ;
  assign status.isMarker = byteData == MARKER;
  assign status.syncOk   = byteData[7:4] == SYNC_NIB;
  assign dataOffset      = markQ;
endmodule

// File: rtl/cfg_hdr_ctrl.sv
module cfg_hdr_ctrl
  import cfg_hdr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic       byteValid,
  input  dpStatus_t  status,
  output ctlStrobe_t stb,
  output logic       byteReady,
  output logic       doneOut
);
  parseState_t stateQ, stateNx;
  logic        finish;
  logic        inParse;

  assign inParse   = stateQ inside {PS_SCAN, PS_HDR0, PS_HDR1, PS_HDR2, PS_HDR3};
  assign byteReady = inParse && !status.atEnd;

  always_comb begin
    stb     = '0;
    stateNx = stateQ;
    finish  = 1'b0;
    if (startIn) begin
      stb.clr = 1'b1;
      stateNx = PS_SCAN;
    end else begin
      unique case (stateQ)
        PS_SCAN: begin
          if (status.atEnd) begin
            stb.setNoStart = 1'b1;
            finish         = 1'b1;
          end else if (byteValid) begin
            stb.take = 1'b1;
            if (status.isMarker) begin
              stb.capMark = 1'b1;
              stateNx     = PS_HDR0;
            end
          end
        end
        PS_HDR0: begin
          if (status.atEnd) begin
            stb.setShort = 1'b1;
            finish       = 1'b1;
          end else if (byteValid) begin
            stb.take = 1'b1;
            if (!status.syncOk) begin
              stb.setBadHdr = 1'b1;
              finish        = 1'b1;
            end else begin
              stb.capHdr[0] = 1'b1;
              stateNx       = PS_HDR1;
            end
          end
        end
        PS_HDR1, PS_HDR2, PS_HDR3: begin
          if (status.atEnd) begin
            stb.setShort = 1'b1;
            finish       = 1'b1;
          end else if (byteValid) begin
            stb.take = 1'b1;
            if (stateQ == PS_HDR1) begin
              stb.capHdr[1] = 1'b1;
              stateNx       = PS_HDR2;
            end else if (stateQ == PS_HDR2) begin
              stb.capHdr[2] = 1'b1;
              stateNx       = PS_HDR3;
            end else begin
              stb.capHdr[3] = 1'b1;
              stateNx       = PS_CHECK;
            end
          end
        end
        PS_CHECK: begin
          stb.checkLen = 1'b1;
          finish       = 1'b1;
        end
        default: ;
      endcase
      if (finish) stateNx = PS_DONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= PS_IDLE;
      doneOut <= 1'b0;
    end else begin
      stateQ  <= stateNx;
      doneOut <= finish;
    end
  end
endmodule

// File: rtl/cfg_hdr_parser.sv
module cfg_hdr_parser
  import cfg_hdr_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [LEN_W-1:0] fileLen,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  output logic             byteReady,
  output logic             doneOut,
  output logic [LEN_W-1:0] dataOffset,
  output logic [CNT_W-1:0] bitCount,
  output logic             errNoStart,
  output logic             errBadHdr,
  output logic             errTooSmall
);
  ctlStrobe_t stb;
  dpStatus_t  status;

  cfg_hdr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .byteValid (byteValid),
    .status    (status),
    .stb       (stb),
    .byteReady (byteReady),
    .doneOut   (doneOut)
  );

  cfg_hdr_dpath #(.LEN_W(LEN_W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .fileLenIn   (fileLen),
    .byteData    (byteData),
    .status      (status),
    .dataOffset  (dataOffset),
    .bitCount    (bitCount),
    .errNoStart  (errNoStart),
    .errBadHdr   (errBadHdr),
    .errTooSmall (errTooSmall)
  );
endmodule

// File: rtl/cfg_hdr_parser_chk.sv
module cfg_hdr_parser_chk #(
  parameter int LEN_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             startIn,
  input logic             byteReady,
  input logic             doneOut,
  input logic [LEN_W-1:0] dataOffset,
  input logic [23:0]      bitCount,
  input logic             errNoStart,
  input logic             errBadHdr,
  input logic             errTooSmall
);
  logic [2:0] errs;
  assign errs = {errNoStart, errBadHdr, errTooSmall};

  AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rstN)
    $countones(errs) <= 1) else $error("one error"); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut) else $error("done pulse"); // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (errs != 3'b000 && $past(errs) == 3'b000) |-> doneOut) else $error("err w/o done"); // R9
  AST_NO_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> !byteReady) else $error("ready at done"); // R10
  AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && !startIn) |=> ($stable(errs) && $stable(dataOffset) && $stable(bitCount)))
    else $error("results moved"); // R10
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> (!doneOut && errs == 3'b000 && bitCount == '0 && dataOffset == '0))
    else $error("start clear"); // R2
endmodule

bind cfg_hdr_parser cfg_hdr_parser_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .startIn(startIn), .byteReady(byteReady),
  .doneOut(doneOut), .dataOffset(dataOffset), .bitCount(bitCount),
  .errNoStart(errNoStart), .errBadHdr(errBadHdr), .errTooSmall(errTooSmall)
);

// File: tb/tb_cfg_hdr_parser.sv
module tb_cfg_hdr_parser;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_N = 48;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [31:0] fileLen = '0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        byteReady, doneOut, errNoStart, errBadHdr, errTooSmall;
  logic [31:0] dataOffset;
  logic [23:0] bitCount;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [7:0] mem [MEM_N];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_hdr_parser dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .fileLen(fileLen),
    .byteValid(byteValid), .byteData(byteData), .byteReady(byteReady),
    .doneOut(doneOut), .dataOffset(dataOffset), .bitCount(bitCount),
    .errNoStart(errNoStart), .errBadHdr(errBadHdr), .errTooSmall(errTooSmall)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // code: 0 pass, 1 no start, 2 bad header, 3 too small
  task automatic runParse(input int len, input int seed, input string tag);
    int code = 0, mark = 0, taken = 0, i = 0;
    logic [23:0] cnt = '0;
    bit hasCnt = 0;
    int ptr = 0, doneCnt = 0, after = 0;
    bit acc;
    while (i < len && mem[i] != 8'hFF) i++;
    if (i >= len) begin
      code = 1; taken = len;
    end else begin
      mark = i;
      if (i + 1 >= len) begin code = 3; taken = len; end
      else if (mem[i+1][7:4] != 4'h2) begin code = 2; taken = i + 2; end
      else if (i + 4 >= len) begin code = 3; taken = len; end
      else begin
        cnt = {mem[i+1][3:0], mem[i+2], mem[i+3], mem[i+4][7:4]};
        hasCnt = 1; taken = i + 5;
        code = ((longint'(mark) + longint'(cnt >> 3)) > longint'(len)) ? 3 : 0;
      end
    end
    @(negedge clk);
    startIn = 1'b1; fileLen = len;
    @(negedge clk);
    startIn = 1'b0;
    chk(!doneOut && !errNoStart && !errBadHdr && !errTooSmall && bitCount == 0 && dataOffset == 0,
        {"R2 clear ", tag}, {errNoStart, errBadHdr, errTooSmall}, 0);
    if (len != 0) chk(byteReady, {"R2 ready ", tag}, byteReady, 1);
    for (int c = 0; c < 300 && after < 5; c++) begin
      if (doneOut) doneCnt++;
      if (doneCnt > 0) after++;
      byteValid = ((c + seed) % 5) != 3;
      byteData  = (ptr < MEM_N) ? mem[ptr] : 8'h00;
      acc = byteValid && byteReady;
      @(posedge clk);
      if (acc) ptr++;
      @(negedge clk);
    end
    byteValid = 1'b0;
    chk(doneCnt == 1, {"R9 done once ", tag}, doneCnt, 1);
    chk(ptr == taken, {"R10 bytes taken ", tag}, ptr, taken);
    chk(!byteReady, {"R10 ready low ", tag}, byteReady, 0);
    chk(errNoStart == (code == 1), {"R4 noStart ", tag}, errNoStart, code == 1);
    chk(errBadHdr == (code == 2), {"R5 badHdr ", tag}, errBadHdr, code == 2);
    chk(errTooSmall == (code == 3), {"R7 R8 tooSmall ", tag}, errTooSmall, code == 3);
    if (code != 1) chk(dataOffset == mark, {"R3 offset ", tag}, dataOffset, mark);
    if (hasCnt) chk(bitCount == cnt, {"R6 count ", tag}, bitCount, cnt);
  endtask

  task automatic fill(input int p, input logic [7:0] b0, input logic [23:0] c, input logic [7:0] pre);
    for (int k = 0; k < MEM_N; k++) mem[k] = pre ^ 8'(k);
    for (int k = 0; k < MEM_N; k++) if (mem[k] == 8'hFF) mem[k] = 8'h7F;
    mem[p]   = 8'hFF;
    mem[p+1] = b0;
    mem[p+2] = c[19:12];
    mem[p+3] = c[11:4];
    mem[p+4] = {c[3:0], 4'h9};
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!byteReady && !doneOut && !errNoStart && !errBadHdr && !errTooSmall &&
        dataOffset == 0 && bitCount == 0, "R1 reset", byteReady, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!byteReady && !doneOut, "R1 idle after reset", byteReady, 0);

    // R5: sweep the sync nibble at several marker positions
    for (int p = 0; p < 6; p++)
      for (int u = 0; u < 16; u++) begin
        fill(p, {4'(u), 4'h0}, 24'h000100, 8'h31);
        runParse(p + 8, u + p, "R5 sync sweep");
      end

    // R7: boundary around offset + count/8 == fileLen
    for (int p = 0; p < 8; p++)
      for (int d = -1; d <= 1; d++)
        for (int extra = 0; extra < 8; extra += 7) begin
          int len = p + 12 + p * 3;
          logic [23:0] c = 24'((len + d - p) * 8 + extra);
          fill(p, {4'h2, c[23:20]}, c, 8'h50);
          runParse(len, p + d + extra, "R7 boundary");
        end

    // R6: nibble placement with a large file length
    fill(3, 8'h2A, 24'hABCDEF, 8'h10);
    runParse(32'h00FF_FFFF, 1, "R6 nibbles");
    fill(0, 8'h25, 24'h5A5A5A, 8'hC3);
    runParse(32'h00FF_FFFF, 2, "R6 nibbles b");

    // R4: no marker within the file, including an empty file
    for (int len = 0; len < 7; len++) begin
      for (int k = 0; k < MEM_N; k++) mem[k] = 8'hFE - 8'(k);
      if (len + 2 < MEM_N) mem[len + 2] = 8'hFF;
      runParse(len, len, "R4 no start");
    end

    // R8: file ends inside the header
    for (int p = 0; p < 4; p++)
      for (int cut = 1; cut <= 4; cut++) begin
        fill(p, 8'h20, 24'h000010, 8'h44);
        runParse(p + cut, cut, "R8 truncated");
      end

    // R2: restart while a parse is in flight, then a clean parse
    fill(2, 8'h20, 24'h000020, 8'h08);
    @(negedge clk);
    startIn = 1'b1; fileLen = 40;
    @(negedge clk);
    startIn = 1'b0; byteValid = 1'b1; byteData = 8'hFF;
    @(negedge clk);
    byteValid = 1'b0;
    runParse(40, 0, "R2 restart");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule